// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a binary counter stage that runs on one system clock. It has two strobe inputs, one for counting up and one for counting down. Each strobe rests HIGH when idle. The stage moves one step on the rising edge of a strobe, but only while the other strobe rests HIGH. Both strobes pass through a synchronizer before the stage acts on them, so they may come from an unrelated timing domain.

A parallel preset input is active low. While it is held low, the value on the data bus is copied into the count. A master clear input is active high. It zeroes the count and overrides both the preset and the strobes. Two active-low terminal outputs follow the LOW phase of the matching strobe, but only while the count sits at its end value. Each terminal output can therefore drive the strobe input of the next stage in a chain.

If the strobes break the one-strobe-at-a-time rule, the count holds and a sticky error flag is raised. Only the master clear lowers that flag.

Top module: `updn_counter`

## Requirements
- R1: A rising edge on `upStrobe` while `dnStrobe` is HIGH adds one to `count`. The new value appears at the third clock edge after the strobe rises. The update is made once per strobe edge.
- R2: A rising edge on `dnStrobe` while `upStrobe` is HIGH subtracts one from `count`. The new value appears at the third clock edge after the strobe rises.
- R3: The count wraps modulo 2^WIDTH. Counting up from 15 gives 0, and counting down from 0 gives 15 (WIDTH = 4).
- R4: While `masterRst` is HIGH, `count` goes to 0 at the next edge and `illegal` clears. The preset input and both strobes have no effect while `masterRst` is HIGH, and no strobe edge is acted on after `masterRst` is released.
- R5: While `loadN` is LOW and `masterRst` is LOW, `count` takes `loadData` at the next edge, whatever the strobes do. A strobe edge seen during a preset does not change the count.
- R6: `tcUpN` is LOW only while `count` is 15 and the synchronized up strobe is LOW. It follows the strobe input two clock edges after that input changes. Otherwise it is HIGH.
- R7: `tcDnN` is LOW only while `count` is 0 and the synchronized down strobe is LOW. Otherwise it is HIGH.
- R8: If rising edges of both strobes are seen in the same cycle, the count holds and `illegal` is set.
- R9: If one strobe rises while the other is LOW, the count holds and `illegal` is set.
- R10: `illegal` stays HIGH until the next master clear. It does not change how legal strobe edges are counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| masterRst | input | 1 | Master clear, active high, sampled at the clock edge |
| loadN | input | 1 | Parallel preset, active low |
| loadData | input | WIDTH | Preset value |
| upStrobe | input | 1 | Count-up strobe, idle HIGH, acts on its rising edge |
| dnStrobe | input | 1 | Count-down strobe, idle HIGH, acts on its rising edge |
| count | output | WIDTH | Current count |
| tcUpN | output | 1 | Terminal-count-up, active low, copies the up strobe at full count |
| tcDnN | output | 1 | Terminal-count-down, active low, copies the down strobe at zero |
| illegal | output | 1 | Sticky illegal-strobe flag |

## Verification
Each result has its own latency, and the checks follow it:

| Result | Due at |
|--------|--------|
| Clear and preset | The first clock edge after the stimulus |
| Terminal outputs | The second clock edge after a strobe level change (two synchronizer flops) |
| Count steps and the error flag | The third clock edge after a strobe rises (two synchronizer flops plus the edge-history flop) |

The table-driven part holds every stimulus for four cycles and samples a quarter period after an edge, so each result has settled before it is read. Directed tests sample at exactly two and three edges after a strobe change. These tests show that the terminal output and the count step do not move a cycle early or late.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Commands passed from the strobe control to the count datapath
  typedef struct packed {
    logic clear;        // master clear
    logic load;         // parallel preset
    logic inc;          // legal up step
    logic dec;          // legal down step
    logic flagIllegal;  // forbidden strobe pattern seen this cycle
  } ctrlCmd_t;

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int  STAGES  = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic clear,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (clear) chain[0] <= IDLE_VAL;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (clear) chain[g] <= IDLE_VAL;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     masterRst,
  input  logic     loadN,
  input  logic     upStrobe,
  input  logic     dnStrobe,
  output logic     upLvl,
  output logic     dnLvl,
  output ctrlCmd_t cmd
);

  logic upPrev, dnPrev;
  logic riseUp, riseDn;

  // Synchronizers rest at the idle HIGH level while cleared, so that
  // releasing the clear never creates a false edge.
  updn_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_syncUp (
    .clk(clk), .clear(masterRst), .din(upStrobe), .dout(upLvl)
  );

  updn_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_syncDn (
    .clk(clk), .clear(masterRst), .din(dnStrobe), .dout(dnLvl)
  );

  always_ff @(posedge clk) begin
    if (masterRst) begin
      upPrev <= 1'b1;
      dnPrev <= 1'b1;
    end else begin
      upPrev <= upLvl;
      dnPrev <= dnLvl;
    end
  end

  assign riseUp = upLvl & ~upPrev;
  assign riseDn = dnLvl & ~dnPrev;

  always_comb begin
    cmd             = '0;
    cmd.clear       = masterRst;
    cmd.load        = ~masterRst & ~loadN;
    cmd.inc         = ~masterRst & riseUp & dnLvl & ~riseDn;
    cmd.dec         = ~masterRst & riseDn & upLvl & ~riseUp;
    cmd.flagIllegal = ~masterRst & ((riseUp & riseDn) |
                                    (riseUp & ~dnLvl) |
                                    (riseDn & ~upLvl));
  end

  // R9: a forbidden pattern never produces a step
  p_hold_on_illegal_r9: assert property (@(posedge clk) disable iff (masterRst)
    cmd.flagIllegal |-> !(cmd.inc || cmd.dec));

  // R1: one strobe edge gives a step command in one cycle only
  p_single_step_r1: assert property (@(posedge clk) disable iff (masterRst)
    cmd.inc |=> !cmd.inc);

endmodule

// File: rtl/updn_dp.sv
module updn_dp
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrlCmd_t         cmd,
  input  logic [WIDTH-1:0] loadData,
  input  logic             upLvl,
  input  logic             dnLvl,
  output logic [WIDTH-1:0] count,
  output logic             tcUpN,
  output logic             tcDnN,
  output logic             illegal
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] MAXV = '1;

  // Priority: clear, then preset, then step. An illegal pattern gives no step.
  always_ff @(posedge clk) begin
    if (cmd.clear) begin
      count   <= '0;
      illegal <= 1'b0;
    end else begin
      if (cmd.load)     count <= loadData;
      else if (cmd.inc) count <= count + ONE;
      else if (cmd.dec) count <= count - ONE;
      if (cmd.flagIllegal) illegal <= 1'b1;
    end
  end

  assign tcUpN = ~((count == MAXV) & ~upLvl);
  assign tcDnN = ~((count == '0)   & ~dnLvl);

  // R1: a step command advances the count by one (modulo, R3)
  p_up_step_r1: assert property (@(posedge clk) disable iff (cmd.clear)
    (cmd.inc && !cmd.load) |=> count == $past(count) + ONE);

  // R2: a down command lowers the count by one
  p_down_step_r2: assert property (@(posedge clk) disable iff (cmd.clear)
    (cmd.dec && !cmd.load) |=> count == $past(count) - ONE);

  // R5: a preset lands the data on the next edge
  p_load_r5: assert property (@(posedge clk) disable iff (cmd.clear)
    cmd.load |=> count == $past(loadData));

  // R8: a forbidden pattern raises the flag
  p_flag_set_r8: assert property (@(posedge clk) disable iff (cmd.clear)
    cmd.flagIllegal |=> illegal);

  // R10: the flag only drops through the master clear
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (cmd.clear)
    illegal |=> illegal);

endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             masterRst,
  input  logic             loadN,
  input  logic [WIDTH-1:0] loadData,
  input  logic             upStrobe,
  input  logic             dnStrobe,
  output logic [WIDTH-1:0] count,
  output logic             tcUpN,
  output logic             tcDnN,
  output logic             illegal
);

  ctrlCmd_t cmd;
  logic     upLvl, dnLvl;

  updn_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .masterRst(masterRst), .loadN(loadN),
    .upStrobe(upStrobe), .dnStrobe(dnStrobe),
    .upLvl(upLvl), .dnLvl(dnLvl), .cmd(cmd)
  );

  updn_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .cmd(cmd), .loadData(loadData),
    .upLvl(upLvl), .dnLvl(dnLvl),
    .count(count), .tcUpN(tcUpN), .tcDnN(tcDnN), .illegal(illegal)
  );

endmodule

// File: tb/updn_counter_test.sv
module updn_counter_test;

  localparam int PERIOD = 10;
  localparam int NV     = 15;

  typedef struct packed {
    logic       up;
    logic       dn;
    logic       ldN;
    logic [3:0] data;
    logic [3:0] cnt;
    logic       tcU;
    logic       tcD;
    logic       ill;
    logic [3:0] req;
  } vec_t;

  // Each row is held four cycles, then all outputs are compared.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b1, 1'b1, 1'b0, 4'd4}, // R4 idle after clear
    '{1'b1, 1'b1, 1'b0, 4'd13, 4'd13, 1'b1, 1'b1, 1'b0, 4'd5}, // R5 preset 13
    '{1'b0, 1'b1, 1'b1, 4'd0,  4'd13, 1'b1, 1'b1, 1'b0, 4'd6}, // R6 up low, not full
    '{1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b1, 1'b1, 1'b0, 4'd1}, // R1 step up
    '{1'b0, 1'b1, 1'b1, 4'd0,  4'd14, 1'b1, 1'b1, 1'b0, 4'd1},
    '{1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1, 1'b1, 1'b0, 4'd1}, // R1 to full
    '{1'b0, 1'b1, 1'b1, 4'd0,  4'd15, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 terminal up low
    '{1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b1, 1'b1, 1'b0, 4'd3}, // R3 wrap up
    '{1'b1, 1'b0, 1'b1, 4'd0,  4'd0,  1'b1, 1'b0, 1'b0, 4'd7}, // R7 terminal down low
    '{1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1, 1'b1, 1'b0, 4'd3}, // R3 wrap down
    '{1'b1, 1'b0, 1'b1, 4'd0,  4'd15, 1'b1, 1'b1, 1'b0, 4'd7}, // R7 not zero
    '{1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b1, 1'b1, 1'b0, 4'd2}, // R2 step down
    '{1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  1'b1, 1'b0, 1'b0, 4'd5}, // R5 preset 0 while dn low
    '{1'b1, 1'b1, 1'b0, 4'd0,  4'd0,  1'b1, 1'b1, 1'b0, 4'd5}, // R5 dn edge during preset
    '{1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b1, 1'b1, 1'b0, 4'd5}
  };

  logic       clk = 1'b0;
  logic       masterRst, loadN, upStrobe, dnStrobe;
  logic [3:0] loadData;
  logic [3:0] count;
  logic       tcUpN, tcDnN, illegal;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  updn_counter uut (
    .clk(clk), .masterRst(masterRst), .loadN(loadN), .loadData(loadData),
    .upStrobe(upStrobe), .dnStrobe(dnStrobe),
    .count(count), .tcUpN(tcUpN), .tcDnN(tcDnN), .illegal(illegal)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    masterRst = 1'b1;
    tick(2);
    masterRst = 1'b0;
    tick(1);
  endtask

  initial begin
    masterRst = 1'b1; loadN = 1'b1; loadData = '0;
    upStrobe = 1'b1; dnStrobe = 1'b1;
    tick(3);
    masterRst = 1'b0;
    tick(1);
    check("R4", "reset count", count, 0);
    check("R4", "reset tcUpN", tcUpN, 1);
    check("R4", "reset tcDnN", tcDnN, 1);
    check("R4", "reset illegal", illegal, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VECS[i].req, i);
      upStrobe = VECS[i].up; dnStrobe = VECS[i].dn;
      loadN = VECS[i].ldN;   loadData = VECS[i].data;
      tick(4);
      check(tag, "count",   count,   VECS[i].cnt);
      check(tag, "tcUpN",   tcUpN,   VECS[i].tcU);
      check(tag, "tcDnN",   tcDnN,   VECS[i].tcD);
      check(tag, "illegal", illegal, VECS[i].ill);
    end

    // R4: clear overrides a preset
    loadN = 1'b0; loadData = 4'd9; masterRst = 1'b1;
    tick(1);
    check("R4", "clear beats preset", count, 0);
    // R4: strobe edges during clear are ignored
    loadN = 1'b1;
    upStrobe = 1'b0; tick(2);
    upStrobe = 1'b1; tick(2);
    masterRst = 1'b0; tick(4);
    check("R4", "strobes ignored in clear", count, 0);

    // R6 / R1 timing at full count
    loadN = 1'b0; loadData = 4'd15; tick(1);
    check("R5", "preset 15", count, 15);
    loadN = 1'b1;
    upStrobe = 1'b0; tick(1);
    check("R6", "tcUpN one edge after fall", tcUpN, 1);
    tick(1);
    check("R6", "tcUpN two edges after fall", tcUpN, 0);
    upStrobe = 1'b1; tick(2);
    check("R6", "tcUpN after rise", tcUpN, 1);
    check("R1", "count before third edge", count, 15);
    tick(1);
    check("R1", "count at third edge", count, 0);
    tick(2);

    // R8: both strobes rise together
    upStrobe = 1'b0; dnStrobe = 1'b0; tick(4);
    upStrobe = 1'b1; dnStrobe = 1'b1; tick(4);
    check("R8", "count holds", count, 0);
    check("R8", "illegal set", illegal, 1);
    // R10: flag sticky, legal counting continues
    upStrobe = 1'b0; tick(4);
    upStrobe = 1'b1; tick(4);
    check("R10", "count after legal step", count, 1);
    check("R10", "illegal sticky", illegal, 1);
    doReset();
    check("R4", "clear drops illegal", illegal, 0);

    // R9: up rises while down is low
    loadN = 1'b0; loadData = 4'd5; tick(1);
    loadN = 1'b1;
    dnStrobe = 1'b0; tick(4);
    upStrobe = 1'b0; tick(4);
    upStrobe = 1'b1; tick(4);
    check("R9", "count holds", count, 5);
    check("R9", "illegal set", illegal, 1);
    dnStrobe = 1'b1; tick(4);
    check("R2", "legal down after illegal", count, 4);
    check("R10", "illegal still set", illegal, 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule